// File: doc/BRIEF.md
# Operating-Point Transition Sequencer

This block carries out changes of the supply/clock operating point that software requests. A write supplies a target voltage code together with a target clock ratio. The block then runs the whole change without further help. It drives the voltage code to the external regulator one step at a time, with a fixed wait between steps. It hands the new ratio to the clock generator with a one-cycle relock request. It holds the core stalled until the clock generator reports that it is locked again.

The direction of the move sets the order of the two halves:

- **Faster clock:** the supply rises first, and the clock relocks afterwards.
- **Slower clock:** the clock relocks first, and the supply falls afterwards.
- **Same ratio:** only the supply moves.

Writes that arrive while a move is under way are not lost. A single slot keeps the newest one, and it starts once the current move ends. A stall watchdog bounds the time the core can stay frozen. If lock is not reported in time, the watchdog releases the stall and raises a sticky error flag.

Top module: `opp_seq_top`

## Requirements
- R1: A write (`wr_en` high at a clock edge) loads the pair (`wr_vid`, `wr_ratio`) into a one-entry pending slot. When the sequencer is idle, the move starts on the next edge and empties the slot.
- R2: When the target ratio is greater than the present `ratio_out`, `vid_out` reaches the target code before `relock_req` is issued.
- R3: `vid_out` changes by exactly one code per step, toward the target. A step occurs once every max(`dwell_cfg`,1) cycles while the code differs from the target.
- R4: When the target ratio is less than the present `ratio_out`, `relock_req` is issued before `vid_out` first changes. The code then ramps to the target.
- R5: `relock_req` is a one-cycle pulse. On the same edge, `ratio_out` takes the target ratio and `core_stall` rises. `core_stall` falls on the edge at which `lock_done` is sampled high, and `vid_out` is held while `core_stall` is high.
- R6: If `lock_done` is not seen within STALL_LIMIT cycles of `core_stall` rising, `core_stall` falls and `lock_err` sets. `lock_err` then stays high until reset, and the voltage half of the move still completes.
- R7: A write whose ratio equals the present `ratio_out` issues no relock. Only the voltage code moves, and it does not move at all when the code also matches.
- R8: Writes made while a move is in progress are deferred, and a later write replaces an earlier pending one. Only the newest pending pair is carried out after the current move.
- R9: `busy` is high from the cycle after an accepted write until the last step of the last pending move has finished.
- R10: After reset, `vid_out` = RST_VID, `ratio_out` = RST_RATIO, and `relock_req`, `core_stall`, `busy` and `lock_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for a new operating point |
| wr_vid | input | VID_W | Target voltage code |
| wr_ratio | input | RATIO_W | Target clock ratio |
| dwell_cfg | input | DWELL_W | Cycles between voltage steps (0 treated as 1) |
| lock_done | input | 1 | Clock generator reports lock |
| vid_out | output | VID_W | Voltage code to the regulator |
| ratio_out | output | RATIO_W | Ratio presented to the clock generator |
| relock_req | output | 1 | One-cycle request to relock at `ratio_out` |
| core_stall | output | 1 | Core (and its cache) held during relock |
| busy | output | 1 | A move is pending or in progress |
| lock_err | output | 1 | Sticky flag: relock watchdog expired |

## Verification
The reference model in the bench is compared against every output on every clock. Each test pattern is chosen to separate one behaviour from its neighbours:

- **Upward move with a three-cycle dwell:** shows that all voltage steps come before the relock.
- **Downward move with a zero dwell:** shows the reverse order, and the one-step-per-cycle floor.
- **Move with an equal ratio:** proves that no relock is issued.
- **Burst of three writes:** shows that the middle one is dropped while the first and last both run.
- **Clock model that never locks:** exercises the watchdog release and the sticky error.
- **Repeat of the present point:** shows that nothing moves.

// File: rtl/opp_pkg.sv
package opp_pkg;

    localparam int VID_W   = 6;
    localparam int RATIO_W = 5;

    typedef struct packed {
        logic [VID_W-1:0]   vid;
        logic [RATIO_W-1:0] ratio;
    } opp_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_VPRE  = 2'd1,
        PH_LOCK  = 2'd2,
        PH_VPOST = 2'd3
    } phase_e;

    function automatic logic [VID_W-1:0] vid_toward(input logic [VID_W-1:0] cur,
                                                    input logic [VID_W-1:0] tgt);
        return (cur < tgt) ? cur + VID_W'(1) : cur - VID_W'(1);
    endfunction

endpackage

// File: rtl/opp_pend_slot.sv
module opp_pend_slot
    import opp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  opp_t wr_op,
    input  logic take,
    output logic valid,
    output opp_t op
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            op    <= '0;
        end else if (wr_en) begin
            valid <= 1'b1;
            op    <= wr_op;
        end else if (take) begin
            valid <= 1'b0;
        end
    end

    // R8: a newer write always overwrites the slot contents
    a_r8_newest_kept: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (valid && op == $past(wr_op)));
endmodule

// File: rtl/opp_vramp.sv
module opp_vramp
    import opp_pkg::*;
#(
    parameter int DWELL_W = 8,
    parameter int RST_VID = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [VID_W-1:0]   tgt_vid,
    input  logic [DWELL_W-1:0] dwell,
    output logic [VID_W-1:0]   vid,
    output logic               at_tgt
);
    logic [DWELL_W-1:0] cnt;
    logic [DWELL_W-1:0] dwell_eff;

    assign dwell_eff = (dwell == '0) ? DWELL_W'(1) : dwell;
    assign at_tgt    = (vid == tgt_vid);

    always_ff @(posedge clk) begin
        if (rst) begin
            vid <= VID_W'(RST_VID);
            cnt <= '0;
        end else if (en && !at_tgt) begin
            if (cnt == dwell_eff - DWELL_W'(1)) begin
                vid <= vid_toward(vid, tgt_vid);
                cnt <= '0;
            end else begin
                cnt <= cnt + DWELL_W'(1);
            end
        end else begin
            cnt <= '0;
        end
    end

    // R3: the code never jumps by more than one step
    a_r3_unit_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(vid) |-> (vid == $past(vid) + VID_W'(1) || vid == $past(vid) - VID_W'(1)));

    // R3: the code only moves while ramping enabled
    a_r3_move_only_enabled: assert property (@(posedge clk) disable iff (rst)
        !$stable(vid) |-> $past(en));
endmodule

// File: rtl/opp_lock_timer.sv
module opp_lock_timer #(
    parameter int STALL_LIMIT = 1250
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic lock_done,
    output logic relock_req,
    output logic core_stall,
    output logic release_now,
    output logic lock_err
);
    localparam int CNT_W = $clog2(STALL_LIMIT + 1);

    logic [CNT_W-1:0] cnt;
    logic             expired;

    assign expired     = (cnt == CNT_W'(STALL_LIMIT - 1));
    assign release_now = core_stall && (lock_done || expired);

    always_ff @(posedge clk) begin
        if (rst) begin
            relock_req <= 1'b0;
            core_stall <= 1'b0;
            lock_err   <= 1'b0;
            cnt        <= '0;
        end else if (start) begin
            relock_req <= 1'b1;
            core_stall <= 1'b1;
            cnt        <= '0;
        end else begin
            relock_req <= 1'b0;
            if (release_now) begin
                core_stall <= 1'b0;
                if (!lock_done) lock_err <= 1'b1;
            end else if (core_stall) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // R5: the stall and the request begin together
    a_r5_stall_with_req: assert property (@(posedge clk) disable iff (rst)
        $rose(core_stall) |-> relock_req);

    // R5: a sampled lock indication ends the stall
    a_r5_lock_releases: assert property (@(posedge clk) disable iff (rst)
        (core_stall && lock_done && !start) |=> !core_stall);

    // R6: the stall never outlives the limit
    a_r6_stall_bounded: assert property (@(posedge clk) disable iff (rst)
        core_stall |-> (cnt < CNT_W'(STALL_LIMIT)));

    // R6: the error flag is sticky
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        lock_err |=> lock_err);
endmodule

// File: rtl/opp_seq_top.sv
module opp_seq_top
    import opp_pkg::*;
#(
    parameter int DWELL_W     = 8,
    parameter int STALL_LIMIT = 1250,
    parameter int RST_VID     = 20,
    parameter int RST_RATIO   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [VID_W-1:0]   wr_vid,
    input  logic [RATIO_W-1:0] wr_ratio,
    input  logic [DWELL_W-1:0] dwell_cfg,
    input  logic               lock_done,
    output logic [VID_W-1:0]   vid_out,
    output logic [RATIO_W-1:0] ratio_out,
    output logic               relock_req,
    output logic               core_stall,
    output logic               busy,
    output logic               lock_err
);
    phase_e             phase, phase_nx;
    opp_t               pend_op, tgt_q;
    logic               pend_valid, take, start_lock, at_tgt, release_now, ramp_en;
    logic [RATIO_W-1:0] lock_ratio;

    opp_pend_slot u_slot (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .wr_op ('{vid: wr_vid, ratio: wr_ratio}),
        .take  (take),
        .valid (pend_valid),
        .op    (pend_op)
    );

    assign take    = (phase == PH_IDLE) && pend_valid;
    assign ramp_en = (phase == PH_VPRE) || (phase == PH_VPOST);

    opp_vramp #(.DWELL_W(DWELL_W), .RST_VID(RST_VID)) u_vramp (
        .clk     (clk),
        .rst     (rst),
        .en      (ramp_en),
        .tgt_vid (tgt_q.vid),
        .dwell   (dwell_cfg),
        .vid     (vid_out),
        .at_tgt  (at_tgt)
    );

    opp_lock_timer #(.STALL_LIMIT(STALL_LIMIT)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .start       (start_lock),
        .lock_done   (lock_done),
        .relock_req  (relock_req),
        .core_stall  (core_stall),
        .release_now (release_now),
        .lock_err    (lock_err)
    );

    always_comb begin
        phase_nx   = phase;
        start_lock = 1'b0;
        lock_ratio = tgt_q.ratio;
        unique case (phase)
            PH_IDLE: if (take) begin
                if (pend_op.ratio > ratio_out) begin
                    phase_nx = PH_VPRE;
                end else if (pend_op.ratio < ratio_out) begin
                    phase_nx   = PH_LOCK;
                    start_lock = 1'b1;
                    lock_ratio = pend_op.ratio;
                end else begin
                    phase_nx = PH_VPOST;
                end
            end
            PH_VPRE: if (at_tgt) begin
                phase_nx   = PH_LOCK;
                start_lock = 1'b1;
            end
            PH_LOCK:  if (release_now) phase_nx = PH_VPOST;
            PH_VPOST: if (at_tgt) phase_nx = PH_IDLE;
            default:  phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            tgt_q     <= '0;
            ratio_out <= RATIO_W'(RST_RATIO);
        end else begin
            phase <= phase_nx;
            if (take)       tgt_q     <= pend_op;
            if (start_lock) ratio_out <= lock_ratio;
        end
    end

    assign busy = (phase != PH_IDLE) || pend_valid;

    // R2: an upward relock follows a completed voltage ramp
    a_r2_up_after_ramp: assert property (@(posedge clk) disable iff (rst)
        (relock_req && ratio_out > $past(ratio_out)) |-> ($past(phase) == PH_VPRE && $past(at_tgt)));

    // R4: a downward relock is the first action of the move
    a_r4_down_first: assert property (@(posedge clk) disable iff (rst)
        (relock_req && ratio_out < $past(ratio_out)) |-> ($past(phase) == PH_IDLE));

    // R7: a relock always changes the ratio
    a_r7_relock_changes: assert property (@(posedge clk) disable iff (rst)
        relock_req |-> (ratio_out != $past(ratio_out)));

    // R5: the voltage code holds during the stall
    a_r5_vid_frozen: assert property (@(posedge clk) disable iff (rst)
        core_stall |-> $stable(vid_out));

    // R5: the ratio moves only with a relock request
    a_r5_ratio_with_req: assert property (@(posedge clk) disable iff (rst)
        !$stable(ratio_out) |-> relock_req);

    // R9: a stall is always part of a busy period
    a_r9_busy_in_stall: assert property (@(posedge clk) disable iff (rst)
        core_stall |-> busy);
endmodule

// File: tb/opp_seq_top_tb.sv
module opp_seq_top_tb;
    import opp_pkg::*;

    localparam int LIM   = 40;
    localparam int LAT   = 3;
    localparam int RVID  = 20;
    localparam int RRAT  = 8;
    localparam int DW    = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               wr_en = 1'b0;
    logic [VID_W-1:0]   wr_vid = '0;
    logic [RATIO_W-1:0] wr_ratio = '0;
    logic [DW-1:0]      dwell_cfg = '0;
    logic               lock_done = 1'b0;
    logic [VID_W-1:0]   vid_out;
    logic [RATIO_W-1:0] ratio_out;
    logic               relock_req, core_stall, busy, lock_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit hang    = 1'b0;

    always #4 clk = ~clk;

    opp_seq_top #(.DWELL_W(DW), .STALL_LIMIT(LIM), .RST_VID(RVID), .RST_RATIO(RRAT)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_vid(wr_vid), .wr_ratio(wr_ratio),
        .dwell_cfg(dwell_cfg), .lock_done(lock_done), .vid_out(vid_out),
        .ratio_out(ratio_out), .relock_req(relock_req), .core_stall(core_stall),
        .busy(busy), .lock_err(lock_err)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    int m_st, m_vid, m_ratio, m_tv, m_tr, m_pv, m_pvid, m_pr, m_cnt, m_scnt, m_stall, m_req, m_err;

    always @(posedge clk) begin : model
        int d, n_st, lr;
        bit tk, rel, enter;
        if (rst) begin
            m_st = 0; m_vid = RVID; m_ratio = RRAT; m_tv = 0; m_tr = 0; m_pv = 0;
            m_pvid = 0; m_pr = 0; m_cnt = 0; m_scnt = 0; m_stall = 0; m_req = 0; m_err = 0;
        end else begin
            d     = (dwell_cfg == 0) ? 1 : int'(dwell_cfg);
            tk    = (m_st == 0) && (m_pv != 0);
            rel   = (m_stall != 0) && (lock_done || m_scnt == LIM - 1);
            enter = 1'b0;
            lr    = m_tr;
            n_st  = m_st;
            case (m_st)
                0: if (tk) begin
                    if (m_pr > m_ratio) n_st = 1;
                    else if (m_pr < m_ratio) begin n_st = 2; enter = 1'b1; lr = m_pr; end
                    else n_st = 3;
                end
                1: if (m_vid == m_tv) begin n_st = 2; enter = 1'b1; end
                2: if (rel) n_st = 3;
                default: if (m_vid == m_tv) n_st = 0;
            endcase
            if ((m_st == 1 || m_st == 3) && m_vid != m_tv) begin
                if (m_cnt == d - 1) begin
                    m_vid = (m_vid < m_tv) ? m_vid + 1 : m_vid - 1;
                    m_cnt = 0;
                end else m_cnt++;
            end else m_cnt = 0;
            if (enter) begin
                m_ratio = lr; m_req = 1; m_stall = 1; m_scnt = 0;
            end else begin
                m_req = 0;
                if (rel) begin
                    m_stall = 0;
                    if (!lock_done) m_err = 1;
                end else if (m_stall != 0) m_scnt++;
            end
            if (tk) begin m_tv = m_pvid; m_tr = m_pr; end
            if (wr_en) begin m_pv = 1; m_pvid = int'(wr_vid); m_pr = int'(wr_ratio); end
            else if (tk) m_pv = 0;
            m_st = n_st;
        end
    end

    // per-cycle comparison, trackers and clock-generator model
    int cyc = 0, prev_vid = RVID, first_vchg = -1, last_vchg = -1, relock_cyc = -1, relock_n = 0;
    int lk_cnt = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            chk(int'(vid_out) == m_vid, "R3", "vid_out", int'(vid_out), m_vid);
            chk(int'(ratio_out) == m_ratio, "R5", "ratio_out", int'(ratio_out), m_ratio);
            chk(int'(relock_req) == m_req, "R5", "relock_req", int'(relock_req), m_req);
            chk(int'(core_stall) == m_stall, "R5", "core_stall", int'(core_stall), m_stall);
            chk(int'(busy) == ((m_st != 0 || m_pv != 0) ? 1 : 0), "R9", "busy", int'(busy),
                (m_st != 0 || m_pv != 0) ? 1 : 0);
            chk(int'(lock_err) == m_err, "R6", "lock_err", int'(lock_err), m_err);
        end
        if (int'(vid_out) != prev_vid) begin
            if (first_vchg < 0) first_vchg = cyc;
            last_vchg = cyc;
        end
        prev_vid = int'(vid_out);
        if (relock_req) begin relock_cyc = cyc; relock_n++; end
        if (lk_cnt > 0) begin
            lk_cnt--;
            lock_done = (lk_cnt == 0);
        end else lock_done = 1'b0;
        if (relock_req && !hang) lk_cnt = LAT;
    end

    task automatic clear_trk();
        @(posedge clk);
        first_vchg = -1; last_vchg = -1; relock_cyc = -1; relock_n = 0;
    endtask

    task automatic write_op(input int v, input int r);
        @(negedge clk);
        wr_en = 1'b1; wr_vid = VID_W'(v); wr_ratio = RATIO_W'(r);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic move(input int v, input int r, input int dw);
        clear_trk();
        @(negedge clk);
        dwell_cfg = DW'(dw);
        write_op(v, r);
        chk(busy == 1'b1, "R9", "busy after write", int'(busy), 1);
        wait_idle();
        chk(busy == 1'b0, "R9", "busy after move", int'(busy), 0);
        chk(int'(vid_out) == v, "R1", "final vid", int'(vid_out), v);
        chk(int'(ratio_out) == r, "R1", "final ratio", int'(ratio_out), r);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 50000, 0);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        chk(int'(vid_out) == RVID, "R10", "reset vid", int'(vid_out), RVID);
        chk(int'(ratio_out) == RRAT, "R10", "reset ratio", int'(ratio_out), RRAT);
        chk({relock_req, core_stall, busy, lock_err} == 4'b0, "R10", "reset flags",
            int'({relock_req, core_stall, busy, lock_err}), 0);

        // R2: upward move, voltage first
        move(30, 12, 3);
        chk(last_vchg >= 0 && last_vchg < relock_cyc, "R2", "last vid step before relock", last_vchg, relock_cyc);
        chk(relock_n == 1, "R2", "relock count", relock_n, 1);

        // R4: downward move, relock first, dwell 0 acts as 1
        move(22, 6, 0);
        chk(relock_cyc >= 0 && relock_cyc < first_vchg, "R4", "relock before first vid step", relock_cyc, first_vchg);

        // R7: equal ratio, no relock
        move(25, 6, 2);
        chk(relock_n == 0, "R7", "relock count equal ratio", relock_n, 0);

        // R8: burst of writes, middle one replaced
        clear_trk();
        @(negedge clk);
        dwell_cfg = DW'(1);
        write_op(40, 14);
        repeat (3) @(negedge clk);
        wr_en = 1'b1; wr_vid = VID_W'(35); wr_ratio = RATIO_W'(10);
        @(negedge clk);
        wr_vid = VID_W'(33); wr_ratio = RATIO_W'(9);
        @(negedge clk);
        wr_en = 1'b0;
        wait_idle();
        chk(int'(vid_out) == 33, "R8", "vid after burst", int'(vid_out), 33);
        chk(int'(ratio_out) == 9, "R8", "ratio after burst", int'(ratio_out), 9);
        chk(relock_n == 2, "R8", "relock count burst", relock_n, 2);

        // R6: clock never locks
        hang = 1'b1;
        move(20, 4, 1);
        chk(lock_err == 1'b1, "R6", "lock_err after timeout", int'(lock_err), 1);
        hang = 1'b0;

        // R7: repeat present point, nothing moves; R6 flag stays
        move(20, 4, 2);
        chk(relock_n == 0, "R7", "no relock on repeat", relock_n, 0);
        chk(first_vchg == -1, "R7", "no vid change on repeat", first_vchg, -1);
        chk(lock_err == 1'b1, "R6", "lock_err sticky", int'(lock_err), 1);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule